// File: doc/BRIEF.md
# Multi-Region Matrix Buffer Reader

This block is the storage and read-sequencing part of a shared on-chip buffer. The buffer is split into seven equal regions that hold network inputs, weights, biases, pre-activation results, activation results, bias gradients and weight gradients. There is one write port with one data word and one valid bit per lane. Either the host or a result write-back path drives it, choosing a region and a start address within that region.

A read command is a single-cycle start pulse. It carries a region code, a start address, a row count, a column count and a transpose flag. The block then walks the stored row-major sub-matrix and emits one element per cycle. In the normal walk it goes row by row. With the transpose flag set it goes column by column. Each element is placed on the output lane that a downstream array row or column expects, with a per-lane valid bit.

The storage is banked by the low address bits so that a memory of the target technology can hold each bank. Region base pointers are fixed internally, and every address wraps inside its region.

Top module: `mrb_reader`

## Requirements
- R1: When `wr_sel` is below 7 and `wr_addr` is below REGION_WORDS (64), each lane i with its valid bit set stores its data word at region `wr_sel`, address (`wr_addr` + i) mod REGION_WORDS. Lanes whose valid bit is clear leave their word unchanged. A write with a region code of 7 or more, or with an out-of-range address, changes nothing.
- R2: Region codes 0 to 6 select seven independent storage areas of REGION_WORDS words each. A write to one region never alters another region.
- R3: `rd_start` is accepted only when `rd_busy` is low and the command is valid with rows and cols both non-zero. `rd_busy` is then high for exactly rows×cols cycles after the accepting edge, and exactly rows×cols elements are emitted.
- R4: With `rd_transpose` low, elements come out in row-major order. Element (r,c) is the word at region address (start + r×cols + c) and is placed on lane c mod LANES.
- R5: With `rd_transpose` high, elements come out in column-major order. The addresses are the same as in R4, and element (r,c) is placed on lane r mod LANES.
- R6: An element appears one cycle after its read address is issued. If the start is accepted at edge E0, element k is on the outputs after edge E(k+1). Exactly one bit of `rd_valid` is high for each element. Lanes that are not valid carry zero data.
- R7: A start pulse while `rd_busy` is high is ignored. The running stream continues unchanged, no error is raised, and no extra elements follow it.
- R8: A start while idle with a region code of 7 or more, or with a start address of REGION_WORDS or more, emits nothing and leaves `rd_busy` low. It raises `rd_err` for exactly the one cycle after the accepting edge.
- R9: A valid start while idle with rows = 0 or cols = 0 emits nothing, leaves `rd_busy` low and raises no error.
- R10: If a read and a write hit the same word at the same clock edge, the read returns the contents from before the write.
- R11: During and just after reset, `rd_busy`, `rd_err` and all `rd_valid` bits are low.
- R12: Read addresses wrap inside the region. Start + offset is taken mod REGION_WORDS, so a read never enters the next region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_sel | input | SEL_W | Region code for the write |
| wr_addr | input | ADDR_W | Start address of the write; lane i writes address + i |
| wr_data | input | LANES×DW | Write data, lane i in bits [i×DW +: DW] |
| wr_valid | input | LANES | Per-lane write enable |
| rd_start | input | 1 | One-cycle read launch |
| rd_sel | input | SEL_W | Region code for the read |
| rd_addr | input | ADDR_W | Start address of the sub-matrix |
| rd_rows | input | ADDR_W | Row count |
| rd_cols | input | ADDR_W | Column count (also the row stride) |
| rd_transpose | input | 1 | Column-major walk when high |
| rd_data | output | LANES×DW | Read data per lane, zero on lanes that are not valid |
| rd_valid | output | LANES | Per-lane output valid |
| rd_busy | output | 1 | High while a read command is being issued |
| rd_err | output | 1 | One-cycle flag for a rejected read command |

## Verification
Two functions can fall in the same cycle: a read address that is being issued, and a host write to that same word. The bench launches a 1×1 read, then drives a write to the target address in the cycle the read address reaches the bank. It expects the old word in the stream and the new word on a second read of that address. A start pulse that lands while a stream is running is a second overlap. Its acceptance is judged by the scoreboard: any element beyond the first command's expected list is reported as unexpected.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

  // Number of named buffer regions; codes at or above this are rejected.
  localparam int NUM_REGIONS = 7;

  typedef enum logic [2:0] {
    RG_INPUT   = 3'd0,
    RG_WEIGHT  = 3'd1,
    RG_BIAS    = 3'd2,
    RG_PREACT  = 3'd3,
    RG_ACT     = 3'd4,
    RG_BGRAD   = 3'd5,
    RG_WGRAD   = 3'd6
  } region_e;

endpackage

// File: rtl/mrb_bank.sv
// One storage bank: synchronous write, synchronous read-first port.
module mrb_bank #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];   // old contents on a same-address collision
  end
endmodule

// File: rtl/mrb_wr_router.sv
// Maps per-lane write words onto address-interleaved banks.
module mrb_wr_router #(
  parameter int LANES        = 2,
  parameter int DW           = 16,
  parameter int ADDR_W       = 16,
  parameter int SEL_W        = 4,
  parameter int REGION_WORDS = 64,
  localparam int LB   = $clog2(LANES),
  localparam int RB   = $clog2(REGION_WORDS),
  localparam int RSEL = $clog2(mrb_pkg::NUM_REGIONS),
  localparam int TOT  = RSEL + RB,
  localparam int BW   = TOT - LB
) (
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [LANES*DW-1:0]   wr_data,
  input  logic [LANES-1:0]      wr_valid,
  output logic [LANES-1:0]      bank_we,
  output logic [LANES*BW-1:0]   bank_wa,
  output logic [LANES*DW-1:0]   bank_wd
);
  logic cmd_ok;
  assign cmd_ok = (int'(wr_sel) < mrb_pkg::NUM_REGIONS) &&
                  (int'(wr_addr) < REGION_WORDS);

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LB-1:0]  src_lane;
    logic [RB-1:0]  loc;
    logic [TOT-1:0] full;
    // Region bases are aligned to REGION_WORDS >= LANES, so consecutive
    // lanes land in distinct banks.
    assign src_lane = LB'(b) - wr_addr[LB-1:0];
    assign loc      = wr_addr[RB-1:0] + RB'(src_lane);
    assign full     = {wr_sel[RSEL-1:0], loc};
    assign bank_we[b]           = cmd_ok && wr_valid[src_lane];
    assign bank_wa[b*BW +: BW]  = full[TOT-1:LB];
    assign bank_wd[b*DW +: DW]  = wr_data[src_lane*DW +: DW];
  end
endmodule

// File: rtl/mrb_walker.sv
// Read command sequencer: walks a rows x cols sub-matrix, one address per cycle.
module mrb_walker #(
  parameter int LANES        = 2,
  parameter int ADDR_W       = 16,
  parameter int SEL_W        = 4,
  parameter int REGION_WORDS = 64,
  localparam int LB   = $clog2(LANES),
  localparam int RB   = $clog2(REGION_WORDS),
  localparam int RSEL = $clog2(mrb_pkg::NUM_REGIONS),
  localparam int TOT  = RSEL + RB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] rows,
  input  logic [ADDR_W-1:0] cols,
  input  logic              transpose,
  output logic              issue,
  output logic [TOT-1:0]    iss_addr,
  output logic [LB-1:0]     iss_lane,
  output logic              busy,
  output logic              err
);
  logic              busy_q, err_q, tr_q;
  logic [RSEL-1:0]   rsel_q;
  logic [RB-1:0]     base_q, off_q, loc;
  logic [ADDR_W-1:0] rows_q, cols_q, r_q, c_q;
  logic              sel_ok, addr_ok, nonempty, accept, last;

  assign sel_ok   = int'(sel) < mrb_pkg::NUM_REGIONS;
  assign addr_ok  = int'(addr) < REGION_WORDS;
  assign nonempty = (rows != '0) && (cols != '0);
  assign accept   = start && !busy_q && sel_ok && addr_ok && nonempty;
  assign last     = (r_q == rows_q - 1'b1) && (c_q == cols_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      tr_q   <= 1'b0;
      rsel_q <= '0;
      base_q <= '0;
      off_q  <= '0;
      rows_q <= '0;
      cols_q <= '0;
      r_q    <= '0;
      c_q    <= '0;
    end else begin
      err_q <= start && !busy_q && !(sel_ok && addr_ok);
      if (accept) begin
        busy_q <= 1'b1;
        tr_q   <= transpose;
        rsel_q <= sel[RSEL-1:0];
        base_q <= addr[RB-1:0];
        rows_q <= rows;
        cols_q <= cols;
        r_q    <= '0;
        c_q    <= '0;
        off_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
        end else if (!tr_q) begin
          // row-major: the linear offset simply advances
          off_q <= off_q + 1'b1;
          if (c_q == cols_q - 1'b1) begin
            c_q <= '0;
            r_q <= r_q + 1'b1;
          end else begin
            c_q <= c_q + 1'b1;
          end
        end else begin
          // column-major: step by the row stride, restart at the next column
          if (r_q == rows_q - 1'b1) begin
            r_q   <= '0;
            c_q   <= c_q + 1'b1;
            off_q <= c_q[RB-1:0] + RB'(1);
          end else begin
            r_q   <= r_q + 1'b1;
            off_q <= off_q + cols_q[RB-1:0];
          end
        end
      end
    end
  end

  assign loc      = base_q + off_q;       // wraps inside the region
  assign iss_addr = {rsel_q, loc};
  assign iss_lane = tr_q ? r_q[LB-1:0] : c_q[LB-1:0];
  assign issue    = busy_q;
  assign busy     = busy_q;
  assign err      = err_q;

  // R7: a start during a stream leaves the latched command untouched
  a_r7_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(rows_q) && $stable(cols_q) &&
                           $stable(tr_q) && $stable(rsel_q) && $stable(base_q)));

  // R8: a rejected command never launches a stream
  a_r8_err_no_launch: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !busy_q);

  // R9: an empty matrix neither launches nor errors
  a_r9_empty_idle: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q && sel_ok && addr_ok && !nonempty) |=> (!busy_q && !err_q));

  // R3: walk indices stay inside the commanded matrix
  a_r3_index_bounds: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((r_q < rows_q) && (c_q < cols_q)));
endmodule

// File: rtl/mrb_reader.sv
// Multi-region matrix buffer with a sub-matrix stream reader.
module mrb_reader #(
  parameter int LANES        = 2,
  parameter int DW           = 16,
  parameter int ADDR_W       = 16,
  parameter int SEL_W        = 4,
  parameter int REGION_WORDS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [LANES*DW-1:0] wr_data,
  input  logic [LANES-1:0]    wr_valid,
  input  logic                rd_start,
  input  logic [SEL_W-1:0]    rd_sel,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [ADDR_W-1:0]   rd_rows,
  input  logic [ADDR_W-1:0]   rd_cols,
  input  logic                rd_transpose,
  output logic [LANES*DW-1:0] rd_data,
  output logic [LANES-1:0]    rd_valid,
  output logic                rd_busy,
  output logic                rd_err
);
  localparam int LB   = $clog2(LANES);
  localparam int RB   = $clog2(REGION_WORDS);
  localparam int RSEL = $clog2(mrb_pkg::NUM_REGIONS);
  localparam int TOT  = RSEL + RB;
  localparam int BW   = TOT - LB;

  logic [LANES-1:0]    bank_we;
  logic [LANES*BW-1:0] bank_wa;
  logic [LANES*DW-1:0] bank_wd;
  logic [DW-1:0]       bank_q [LANES];

  logic                w_issue;
  logic [TOT-1:0]      w_addr;
  logic [LB-1:0]       w_lane;

  logic                v_q;
  logic [LB-1:0]       lane_q;
  logic [LB-1:0]       bsel_q;

  mrb_wr_router #(
    .LANES(LANES), .DW(DW), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .REGION_WORDS(REGION_WORDS)
  ) u_router (
    .wr_sel  (wr_sel),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_valid(wr_valid),
    .bank_we (bank_we),
    .bank_wa (bank_wa),
    .bank_wd (bank_wd)
  );

  mrb_walker #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .REGION_WORDS(REGION_WORDS)
  ) u_walker (
    .clk      (clk),
    .rst      (rst),
    .start    (rd_start),
    .sel      (rd_sel),
    .addr     (rd_addr),
    .rows     (rd_rows),
    .cols     (rd_cols),
    .transpose(rd_transpose),
    .issue    (w_issue),
    .iss_addr (w_addr),
    .iss_lane (w_lane),
    .busy     (rd_busy),
    .err      (rd_err)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    mrb_bank #(.DW(DW), .AW(BW)) u_bank (
      .clk(clk),
      .we (bank_we[b]),
      .wa (bank_wa[b*BW +: BW]),
      .wd (bank_wd[b*DW +: DW]),
      .re (w_issue),
      .ra (w_addr[TOT-1:LB]),
      .q  (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      lane_q <= '0;
      bsel_q <= '0;
    end else begin
      v_q    <= w_issue;
      lane_q <= w_lane;
      bsel_q <= w_addr[LB-1:0];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign rd_valid[l]          = v_q && (lane_q == LB'(l));
    assign rd_data[l*DW +: DW]  = rd_valid[l] ? bank_q[bsel_q] : '0;
  end

  // R6: output valid follows an issued address by exactly one cycle
  a_r6_valid_after_issue: assert property (@(posedge clk) disable iff (rst)
    ((|rd_valid) == $past(w_issue)));

  // R6: at most one lane carries an element
  a_r6_single_lane: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_valid));

  // R11: nothing is emitted right after reset
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (rd_valid == '0 && !rd_busy));
endmodule

// File: tb/mrb_reader_tb.sv
`timescale 1ns/1ps
module mrb_reader_tb;
  localparam int RW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_valid = '0;
  logic        rd_start = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_addr = '0, rd_rows = '0, rd_cols = '0;
  logic        rd_transpose = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  rd_valid;
  logic        rd_busy, rd_err;

  mrb_reader u_dut (
    .clk(clk), .rst(rst),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_start(rd_start), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_rows(rd_rows), .rd_cols(rd_cols), .rd_transpose(rd_transpose),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_busy(rd_busy), .rd_err(rd_err)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [7][RW];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (|rd_valid)) begin
      int ln;
      ln = rd_valid[1] ? 1 : 0;
      chk($countones(rd_valid) == 1, "R6", "one valid lane", 32'(rd_valid), 32'h1);
      chk(rd_data[(1-ln)*16 +: 16] == 16'h0, "R6", "idle lane data", 32'(rd_data[(1-ln)*16 +: 16]), 32'h0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected element", {16'(ln), rd_data[ln*16 +: 16]}, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({16'(ln), rd_data[ln*16 +: 16]} == e, t, "lane/data", {16'(ln), rd_data[ln*16 +: 16]}, e);
      end
    end
  end

  task automatic wr(input int sel, input int addr, input logic [15:0] d0,
                    input logic [15:0] d1, input logic [1:0] vm);
    @(negedge clk);
    wr_sel = 4'(sel); wr_addr = 16'(addr); wr_data = {d1, d0}; wr_valid = vm;
    @(negedge clk);
    wr_valid = '0;
    if (sel < 7 && addr < RW) begin
      if (vm[0]) mdl[sel][addr % RW] = d0;
      if (vm[1]) mdl[sel][(addr + 1) % RW] = d1;
    end
  endtask

  function automatic int push_exp(input int sel, input int addr, input int rows,
                                  input int cols, input bit tr, input string tag);
    int n = 0;
    if (sel >= 7 || addr >= RW) return 0;
    for (int a = 0; a < (tr ? cols : rows); a++) begin
      for (int b = 0; b < (tr ? rows : cols); b++) begin
        int r, c, ln;
        r  = tr ? b : a;
        c  = tr ? a : b;
        ln = tr ? (r % 2) : (c % 2);
        exp_q.push_back({16'(ln), mdl[sel][(addr + r * cols + c) % RW]});
        tag_q.push_back(tag);
        n++;
      end
    end
    return n;
  endfunction

  task automatic drive_start(input int sel, input int addr, input int rows,
                             input int cols, input bit tr);
    rd_start = 1'b1; rd_sel = 4'(sel); rd_addr = 16'(addr);
    rd_rows = 16'(rows); rd_cols = 16'(cols); rd_transpose = tr;
  endtask

  task automatic rd(input int sel, input int addr, input int rows, input int cols,
                    input bit tr, input string tag);
    int n, bc;
    n = push_exp(sel, addr, rows, cols, tr, tag);
    @(negedge clk);
    drive_start(sel, addr, rows, cols, tr);
    @(negedge clk);
    rd_start = 1'b0;
    if (n > 0) begin
      chk(rd_busy == 1'b1, "R3", "busy after accept", 32'(rd_busy), 32'h1);
      chk(rd_valid == 2'b00, "R6", "no data yet", 32'(rd_valid), 32'h0);
      bc = 0;
      while (rd_busy && bc < 4096) begin
        bc++;
        @(negedge clk);
        if (bc == 1) chk(|rd_valid, "R6", "first element timing", 32'(rd_valid), 32'h1);
      end
      chk(bc == n, "R3", "busy cycles", 32'(bc), 32'(n));
    end else begin
      bit bad;
      bad = (sel >= 7) || (addr >= RW);
      chk(rd_busy == 1'b0, bad ? "R8" : "R9", "stays idle", 32'(rd_busy), 32'h0);
      chk(rd_err == bad, bad ? "R8" : "R9", "error flag", 32'(rd_err), 32'(bad));
      @(negedge clk);
      chk(rd_err == 1'b0, "R8", "error lasts one cycle", 32'(rd_err), 32'h0);
    end
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, tag, "stream complete", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rd_busy, rd_err, rd_valid} == 4'b0, "R11", "in reset", 32'({rd_busy, rd_err, rd_valid}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk({rd_busy, rd_err, rd_valid} == 4'b0, "R11", "after reset", 32'({rd_busy, rd_err, rd_valid}), 32'h0);

    // R2: fill regions 0 and 1 with distinct patterns at the same addresses
    for (int a = 0; a < 24; a += 2) begin
      wr(0, a, 16'h0100 + 16'(a), 16'h0101 + 16'(a), 2'b11);
      wr(1, a, 16'h1100 + 16'(a), 16'h1101 + 16'(a), 2'b11);
    end
    rd(0, 0, 1, 4, 1'b0, "R2");
    rd(1, 0, 1, 4, 1'b0, "R2");

    // R1: partial-lane write, invalid-region write, out-of-range write
    wr(0, 20, 16'hAAAA, 16'hBBBB, 2'b01);
    wr(9, 20, 16'hDEAD, 16'hBEEF, 2'b11);
    wr(0, 66, 16'hDEAD, 16'hBEEF, 2'b11);
    rd(0, 20, 1, 2, 1'b0, "R1");
    rd(1, 20, 1, 2, 1'b0, "R1");
    rd(0, 2, 1, 2, 1'b0, "R1");

    // R4: row-major 2x3, R5: transposed 3x2 with lane by row
    rd(0, 2, 2, 3, 1'b0, "R4");
    rd(1, 1, 3, 2, 1'b1, "R5");
    rd(0, 0, 4, 3, 1'b1, "R5");

    // R7: start pulses during a running stream
    n = push_exp(0, 0, 2, 3, 1'b0, "R7");
    @(negedge clk);
    drive_start(0, 0, 2, 3, 1'b0);
    @(negedge clk);
    drive_start(1, 0, 3, 3, 1'b1);
    @(negedge clk);
    drive_start(8, 0, 1, 1, 1'b0);
    @(negedge clk);
    rd_start = 1'b0;
    chk(rd_err == 1'b0, "R7", "no error while busy", 32'(rd_err), 32'h0);
    while (rd_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "only first stream", 32'(exp_q.size()), 32'h0);

    // R8: bad region code and bad start address; R9: empty matrices
    rd(7, 0, 2, 2, 1'b0, "R8");
    rd(0, 64, 1, 1, 1'b0, "R8");
    rd(0, 0, 0, 3, 1'b0, "R9");
    rd(2, 0, 3, 0, 1'b1, "R9");

    // R10: write to the word being read in the same edge
    wr(3, 4, 16'h3004, 16'h3005, 2'b11);
    n = push_exp(3, 5, 1, 1, 1'b0, "R10");
    @(negedge clk);
    drive_start(3, 5, 1, 1, 1'b0);
    @(negedge clk);
    rd_start = 1'b0;
    wr_sel = 4'd3; wr_addr = 16'd5; wr_data = {16'h0, 16'h5A5A}; wr_valid = 2'b01;
    @(negedge clk);
    wr_valid = '0;
    mdl[3][5] = 16'h5A5A;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "old word seen", 32'(exp_q.size()), 32'h0);
    rd(3, 5, 1, 1, 1'b0, "R10");

    // R12: wrap inside a region on write and read
    wr(2, 62, 16'h2062, 16'h2063, 2'b11);
    wr(2, 63, 16'h2163, 16'h2100, 2'b11);
    wr(2, 1, 16'h2101, 16'h0, 2'b01);
    wr(3, 0, 16'h3333, 16'h3334, 2'b11);
    rd(2, 62, 1, 4, 1'b0, "R12");
    rd(2, 62, 2, 2, 1'b1, "R12");

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule